// File: doc/BRIEF.md
# Return Address Prediction Stack

This block guesses where a return instruction will jump before the return is executed. Each call deposits its fall-through address on a small circular stack. Each return is predicted from the top entry, and that entry is then removed. The front end presents at most one call event and one return event per cycle. The prediction and its valid bit come straight from the current top of the stack, so a return can use them in the same cycle it is signalled.

The stack has a fixed number of slots. When a call arrives and every slot is taken, the slot holding the oldest address is reused. That address is lost for good. Calls and returns that do not pair up leave the stack shifted against the program, and the returns that follow are predicted wrongly until the shift works its way out. A call whose target is simply the next instruction is a way for code to read its own address. Such a call is flagged and leaves the stack untouched.

Control is a three-state machine. ST_EMPTY holds no entries. ST_PARTIAL holds between one entry and one less than full. ST_FULL holds every slot. The transitions are:
- fill: ST_EMPTY to ST_PARTIAL on a push.
- top_off: ST_PARTIAL to ST_FULL on a push at depth minus one.
- drain: ST_PARTIAL to ST_EMPTY on a pop at one entry.
- unload: ST_FULL to ST_PARTIAL on a pop.

In every other case the state holds. This includes a push while full, which overwrites the oldest entry, and a simultaneous pop and push, which swaps the top entry.

Top module: `ras_predictor`

## Requirements
- R1: After reset `pred_valid_o` is 0 and `pred_addr_o` is 0.
- R2: A cycle with `call_i`=1 and `call_next_i`=0 pushes `call_addr_i`. From the next cycle `pred_valid_o` is 1 and `pred_addr_o` equals that address.
- R3: A cycle with `ret_i`=1 on a non-empty stack removes the top entry. The prediction then shows the entry pushed before it, in last-in first-out order.
- R4: A call with `call_next_i`=1 and no return leaves `pred_valid_o` and `pred_addr_o` unchanged in the following cycle.
- R5: After more calls than `DEPTH` without returns, only the newest `DEPTH` addresses are predicted, newest first. The next return after those finds the stack empty.
- R6: A return while `pred_valid_o`=0 is ignored. The stack stays empty and later pushes and pops behave normally.
- R7: When a pushing call and a return arrive together on a non-empty stack, the prediction in that cycle is the old top. Next cycle the top is the new address and the entries beneath it are unchanged.
- R8: A pushing call together with a return on an empty stack acts as a plain push.
- R9: A call left unmatched by a return shifts the stack. The next return is predicted with the unmatched call's address rather than the caller's.
- R10: Whenever `pred_valid_o` is 0, `pred_addr_o` is 0.
- R11: A return together with a call flagged by `call_next_i`=1 acts as a plain return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | A call is executed this cycle |
| call_next_i | input | 1 | The call's target is the next sequential instruction |
| call_addr_i | input | AW | Return address of the call |
| ret_i | input | 1 | A return is executed this cycle |
| pred_addr_o | output | AW | Predicted return target, 0 when not valid |
| pred_valid_o | output | 1 | The stack holds at least one entry |

## Verification
A return and a pushing call can land in the same cycle. The block handles this by reading first: it predicts the old top, then writes the new address into that same slot. The bench raises both events together on a partly filled stack, on a full stack and on an empty one. It also raises a return together with a call flagged as call-to-next. In every case it compares the prediction shown during the shared cycle, and the stack contents revealed by the returns that follow, against a queue model that applies the pop before the push.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } ras_state_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } ras_op_e;

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_req_i,
    output logic          valid_o,
    output logic          wr_en_o,
    output logic [PW-1:0] wr_idx_o,
    output logic [PW-1:0] rd_idx_o
);

    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    ras_state_e    state_q, state_d;
    ras_op_e       op;
    logic [PW-1:0] sp_q, sp_d;
    logic [CW-1:0] cnt_q, cnt_d;

    function automatic logic [PW-1:0] idx_inc(input logic [PW-1:0] v);
        return (v == LAST_IDX) ? '0 : v + PW'(1);
    endfunction

    function automatic logic [PW-1:0] idx_dec(input logic [PW-1:0] v);
        return (v == '0) ? LAST_IDX : v - PW'(1);
    endfunction

    // The return is taken first, so a return on an empty stack is dropped
    always_comb begin
        logic pop_ok;
        pop_ok = pop_req_i && (state_q != ST_EMPTY);
        unique case ({push_i, pop_ok})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_IDLE;
        endcase
    end

    // Next state, stack pointer and occupancy
    always_comb begin
        state_d = state_q;
        sp_d    = sp_q;
        cnt_d   = cnt_q;
        unique case (op)
            OP_PUSH: begin
                sp_d  = idx_inc(sp_q);
                cnt_d = (cnt_q == CNT_FULL) ? cnt_q : cnt_q + CW'(1);
            end
            OP_POP: begin
                sp_d  = idx_dec(sp_q);
                cnt_d = cnt_q - CW'(1);
            end
            OP_SWAP, OP_IDLE: ;
        endcase
        unique case (state_q)
            ST_EMPTY: begin
                if (op == OP_PUSH) state_d = ST_PARTIAL;            // fill
            end
            ST_PARTIAL: begin
                if (op == OP_PUSH && cnt_q == CNT_FULL - CW'(1))
                    state_d = ST_FULL;                              // top_off
                else if (op == OP_POP && cnt_q == CNT_ONE)
                    state_d = ST_EMPTY;                             // drain
            end
            ST_FULL: begin
                if (op == OP_POP) state_d = ST_PARTIAL;             // unload
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            sp_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            sp_q    <= sp_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        valid_o  = (state_q != ST_EMPTY);
        wr_en_o  = (op == OP_PUSH) || (op == OP_SWAP);
        wr_idx_o = (op == OP_SWAP) ? idx_dec(sp_q) : sp_q;
        rd_idx_o = idx_dec(sp_q);
    end

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_idx_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [AW-1:0] rd_data_o
);

    logic [AW-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en_i && wr_idx_i == PW'(g)) slot[g] <= wr_data_i;
        end
    end

    assign rd_data_o = slot[rd_idx_i];

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          call_next_i,
    input  logic [AW-1:0] call_addr_i,
    input  logic          ret_i,
    output logic [AW-1:0] pred_addr_o,
    output logic          pred_valid_o
);

    logic          push;
    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic [PW-1:0] rd_idx;
    logic [AW-1:0] rd_data;
    logic          valid;

    // A call to the next instruction does not touch the stack
    assign push = call_i && !call_next_i;

    ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .pop_req_i (ret_i),
        .valid_o   (valid),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .rd_idx_o  (rd_idx)
    );

    ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (call_addr_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    assign pred_valid_o = valid;
    assign pred_addr_o  = valid ? rd_data : '0;

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          call_i,
    input logic          call_next_i,
    input logic [AW-1:0] call_addr_i,
    input logic          ret_i,
    input logic [AW-1:0] pred_addr_o,
    input logic          pred_valid_o
);

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !call_next_i) |=> (pred_valid_o && pred_addr_o == $past(call_addr_i))); // R2

    AST_NEXT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && call_next_i && !ret_i) |=> ($stable(pred_valid_o) && $stable(pred_addr_o))); // R4

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_valid_o && ret_i && !call_i) |=> !pred_valid_o); // R6

    AST_SWAP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid_o && ret_i && call_i && !call_next_i) |=> pred_valid_o); // R7

    AST_EMPTY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_valid_o && ret_i && call_i && !call_next_i) |=> pred_valid_o); // R8

    AST_ZERO_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid_o |-> (pred_addr_o == '0)); // R10

endmodule

bind ras_predictor ras_checker #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .call_i       (call_i),
    .call_next_i  (call_next_i),
    .call_addr_i  (call_addr_i),
    .ret_i        (ret_i),
    .pred_addr_o  (pred_addr_o),
    .pred_valid_o (pred_valid_o)
);

// File: tb/sim_ras_predictor.sv
module sim_ras_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int AW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_i = 1'b0;
    logic          call_next_i = 1'b0;
    logic [AW-1:0] call_addr_i = '0;
    logic          ret_i = 1'b0;
    logic [AW-1:0] pred_addr_o;
    logic          pred_valid_o;

    int            n_vec = 0;
    int            n_bad = 0;
    int            cyc   = 0;
    string         cur_req = "R1";
    logic [AW-1:0] model [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ras_predictor #(.DEPTH(DEPTH), .AW(AW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .call_i       (call_i),
        .call_next_i  (call_next_i),
        .call_addr_i  (call_addr_i),
        .ret_i        (ret_i),
        .pred_addr_o  (pred_addr_o),
        .pred_valid_o (pred_valid_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected under 50000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic compare();
        logic          ev;
        logic [AW-1:0] ea;
        ev = (model.size() != 0);
        ea = ev ? model[$] : '0;
        n_vec++;
        if (pred_valid_o !== ev || pred_addr_o !== ea) begin
            n_bad++;
            $display("FAIL %s: actual valid=%0b addr=%h, expected valid=%0b addr=%h",
                     cur_req, pred_valid_o, pred_addr_o, ev, ea);
        end
    endtask

    // Compare the outputs, then present the events for the next edge
    task automatic step(input logic c, input logic n, input logic r, input logic [AW-1:0] a);
        @(negedge clk);
        compare();
        call_i      = c;
        call_next_i = n;
        ret_i       = r;
        call_addr_i = a;
        if (r && model.size() != 0) void'(model.pop_back());
        if (c && !n) begin
            model.push_back(a);
            if (model.size() > DEPTH) void'(model.pop_front());
        end
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        idle();

        cur_req = "R2";
        step(1'b1, 1'b0, 1'b0, 16'h1000);
        step(1'b1, 1'b0, 1'b0, 16'h2000);
        step(1'b1, 1'b0, 1'b0, 16'h3000);
        idle();

        cur_req = "R4";
        step(1'b1, 1'b1, 1'b0, 16'hDEAD);
        step(1'b1, 1'b1, 1'b0, 16'hBEEF);
        idle();

        cur_req = "R3";
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, '0);
        idle();

        cur_req = "R6";
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, '0);
        step(1'b1, 1'b0, 1'b0, 16'h0A0A);
        step(1'b0, 1'b0, 1'b1, '0);
        idle();

        cur_req = "R10";
        idle();

        cur_req = "R5";
        for (int i = 0; i < DEPTH + 3; i++) step(1'b1, 1'b0, 1'b0, AW'(16'h4000 + i));
        for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b0, 1'b1, '0);
        idle();

        cur_req = "R7";
        step(1'b1, 1'b0, 1'b0, 16'h5001);
        step(1'b1, 1'b0, 1'b0, 16'h5002);
        step(1'b1, 1'b0, 1'b1, 16'h5003);
        step(1'b1, 1'b0, 1'b1, 16'h5004);
        step(1'b1, 1'b0, 1'b0, 16'h5005);
        step(1'b1, 1'b0, 1'b0, 16'h5006);
        step(1'b1, 1'b0, 1'b1, 16'h5007);
        for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 1'b0, 1'b1, '0);
        idle();

        cur_req = "R8";
        step(1'b1, 1'b0, 1'b1, 16'h6001);
        idle();
        step(1'b0, 1'b0, 1'b1, '0);
        idle();

        cur_req = "R9";
        step(1'b1, 1'b0, 1'b0, 16'h7100);
        step(1'b1, 1'b0, 1'b0, 16'h7200);
        step(1'b0, 1'b0, 1'b1, '0);
        step(1'b0, 1'b0, 1'b1, '0);
        idle();

        cur_req = "R11";
        step(1'b1, 1'b0, 1'b0, 16'h8100);
        step(1'b1, 1'b0, 1'b0, 16'h8200);
        step(1'b1, 1'b1, 1'b1, 16'h8FFF);
        step(1'b0, 1'b0, 1'b1, '0);
        idle();

        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            logic c, n, r;
            c = ($urandom_range(0, 99) < 45);
            n = ($urandom_range(0, 99) < 15);
            r = ($urandom_range(0, 99) < 45);
            step(c, n, r, AW'($urandom));
        end
        idle();
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule